// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects interrupt requests from a fixed set of sources, by default nineteen, and presents one interrupt line and an 8-bit vector to a processor. Each source has its own 16-bit control word. The word holds the vector, a pending flag, two enable bits (one for internally generated requests and one for requests from outside the chip), an edge/level selector and a polarity inverter. Requests arrive as synchronous levels. In level mode a source pends while its conditioned input is active and stops pending when the input is withdrawn. In edge mode a source pends on an activating transition and stays pending until it is acknowledged or rewritten.

The processor reaches the control words through a register bus with one 16-bit slot per source. The slot just after the last source holds two 8-bit storage registers: a software-interrupt byte and an NMI-control byte. With the default count, that slot and the last source slot together fill one 32-bit word.

Software can request an interrupt on any source in two writes. The first write, with the pending bit set, arms a hidden force flag. The second write stores its data and raises the interrupt if the new data enables the source. When several sources pend, the lowest-numbered one is current. An acknowledge pulse clears the current source and lets the next one take over.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, every source slot and the auxiliary slot read 0x0000, `irq_o` is low and `vector_o` is 0x00.
- R2: A write without bit 8 to a source slot that is not armed stores the data. Reading the slot returns the stored data with bit 8 (pending) and bit 15 cleared.
- R3: A request is accepted only if bit 9 (external enable) or bit 12 (internal enable) of its slot is set. While both bits are clear, the source never pends and `irq_o` is unaffected.
- R4: In level mode (bit 10 = 0), an enabled source with an active conditioned request sets pending (bit 8) at the next clock edge. The source clears pending at the edge where the conditioned request goes inactive.
- R5: In edge mode (bit 10 = 1), an enabled source pends on an inactive-to-active transition of its conditioned request. It stays pending after the request drops, until it is acknowledged or its slot is written.
- R6: Bit 11 inverts the request, so that with bit 11 set a low input counts as active.
- R7: A write with bit 8 set arms the slot: it stores the data with pending cleared and sets a hidden force flag, which reads back as 0 at bit 15. The next write to an armed slot, if its bit 8 is clear, stores the data and sets pending when bit 9 or bit 12 of the new data is set.
- R8: The current source is the lowest-numbered pending source. `irq_o` is high exactly when some source is pending. `vector_o` carries bits 7:0 of the current source's slot, or 0x00 when nothing is pending.
- R9: A one-cycle `ack_i` pulse clears pending on the current source at that edge. The next pending source, if any, then becomes current.
- R10: The slot at address NUM_SRC is plain storage: bits 7:0 hold the software-interrupt byte and bits 15:8 the NMI-control byte. Writes to other slots leave it unchanged.
- R11: When a register write to a slot and a hardware event on that same slot fall in the same cycle, the written value wins. An acknowledge and a new request on two different sources in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_SRC | Request level of each source |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Slot index (0..NUM_SRC-1 sources, NUM_SRC auxiliary) |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data of the addressed slot |
| ack_i | input | 1 | Interrupt acknowledge pulse |
| irq_o | output | 1 | Interrupt request to the processor |
| vector_o | output | 8 | Vector of the current source |

## Verification
Two functions can land in the same cycle. The first is an acknowledge that retires the current source while a request on a lower-numbered source arrives. The second is a register write to a slot while its own hardware request becomes active. The bench provokes the first by pulsing `ack_i` and a new edge request together. It expects the new source's vector next and the acknowledged slot read back without its pending bit. For the second, it drives a write and a request for the same slot on one edge. It expects the written value, not pending, for one cycle, then pending from the still-active request on the following edge.

// File: rtl/vic_pkg.sv
package vic_pkg;
   localparam int CTRL_W     = 16;
   localparam int VEC_W      = 8;
   localparam int BIT_PEND   = 8;
   localparam int BIT_EXT_EN = 9;
   localparam int BIT_EDGE   = 10;
   localparam int BIT_NEG    = 11;
   localparam int BIT_INT_EN = 12;
   localparam int BIT_FORCE  = 15;
   localparam int AUX_HALF   = 8;

   typedef logic [CTRL_W-1:0] ctrl_t;
endpackage

// File: rtl/vic_src_slot.sv
module vic_src_slot
   import vic_pkg::*;
#(
   parameter int IDX    = 0,
   parameter int ADDR_W = 5
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  ctrl_t             wdata_i,
   input  logic              ack_hit_i,
   output ctrl_t             ctrl_o,
   output logic              pend_o
);
   ctrl_t ctrl_q, ctrl_d;
   logic  req_prev_q;
   logic  hit, neg_pol, edge_mode, enabled;
   logic  cond_now, cond_prev, rise, fall, event_on;
   logic  new_en;
   logic  unused_wd15;

   assign unused_wd15 = wdata_i[BIT_FORCE];

   assign hit       = wr_i && (addr_i == ADDR_W'(IDX));
   assign neg_pol   = ctrl_q[BIT_NEG];
   assign edge_mode = ctrl_q[BIT_EDGE];
   assign enabled   = ctrl_q[BIT_EXT_EN] || ctrl_q[BIT_INT_EN];
   assign cond_now  = req_i ^ neg_pol;
   assign cond_prev = req_prev_q ^ neg_pol;
   assign rise      = cond_now && !cond_prev;
   assign fall      = cond_prev && !cond_now;
   assign event_on  = edge_mode ? rise : cond_now;
   assign new_en    = wdata_i[BIT_EXT_EN] || wdata_i[BIT_INT_EN];

   always_comb begin
      ctrl_d = ctrl_q;
      if (hit) begin
         ctrl_d            = wdata_i;
         ctrl_d[BIT_FORCE] = wdata_i[BIT_PEND];
         ctrl_d[BIT_PEND]  = !wdata_i[BIT_PEND] && ctrl_q[BIT_FORCE] && new_en;
      end else if (ack_hit_i) begin
         ctrl_d[BIT_PEND] = 1'b0;
      end else if (event_on && enabled) begin
         ctrl_d[BIT_PEND] = 1'b1;
      end else if (!edge_mode && fall) begin
         ctrl_d[BIT_PEND] = 1'b0;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ctrl_q     <= '0;
         req_prev_q <= 1'b0;
      end else begin
         ctrl_q     <= ctrl_d;
         req_prev_q <= req_i;
      end
   end

   assign ctrl_o = ctrl_q;
   assign pend_o = ctrl_q[BIT_PEND];

   AST_GATE_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!hit && !enabled && !pend_o) |=> !pend_o); // R3
   AST_LEVEL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!hit && !edge_mode && fall) |=> !pend_o); // R4
   AST_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!hit && !ack_hit_i && edge_mode && pend_o) |=> pend_o); // R5
   AST_ARM_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit && wdata_i[BIT_PEND]) |=> (!pend_o && ctrl_q[BIT_FORCE])); // R7
   AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_hit_i && !hit) |=> !pend_o); // R9
endmodule

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
   parameter int NUM = 19,
   localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
   input  logic [NUM-1:0]   pend_i,
   output logic [NUM-1:0]   grant_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             any_o
);
   always_comb begin
      idx_o = '0;
      for (int i = NUM - 1; i >= 0; i--) begin
         if (pend_i[i]) idx_o = IDX_W'(i);
      end
      any_o   = |pend_i;
      grant_o = any_o ? (NUM'(1) << idx_o) : '0;
   end

   always_comb begin
      if (any_o) begin
         AST_GRANT_LOWEST: assert ((pend_i & (grant_o - NUM'(1))) == '0); // R8
         AST_GRANT_ONE: assert ($onehot0(grant_o) && ((grant_o & pend_i) != '0)); // R8
      end
   end
endmodule

// File: rtl/vic_aux_regs.sv
module vic_aux_regs
   import vic_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int SLOT   = 19
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  ctrl_t             wdata_i,
   output ctrl_t             word_o
);
   logic [AUX_HALF-1:0] soft_q, nmi_q;
   logic hit;

   assign hit = wr_i && (addr_i == ADDR_W'(SLOT));

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         soft_q <= '0;
         nmi_q  <= '0;
      end else if (hit) begin
         soft_q <= wdata_i[AUX_HALF-1:0];
         nmi_q  <= wdata_i[CTRL_W-1:AUX_HALF];
      end
   end

   assign word_o = {nmi_q, soft_q};

   AST_AUX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hit |=> $stable(word_o)); // R10
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
   import vic_pkg::*;
#(
   parameter int NUM_SRC = 19,
   parameter int ADDR_W  = 5
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [NUM_SRC-1:0]    req_i,
   input  logic                  bus_wr_i,
   input  logic [ADDR_W-1:0]     bus_addr_i,
   input  logic [CTRL_W-1:0]     bus_wdata_i,
   output logic [CTRL_W-1:0]     bus_rdata_o,
   input  logic                  ack_i,
   output logic                  irq_o,
   output logic [VEC_W-1:0]      vector_o
);
   localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam logic [ADDR_W-1:0] AUX_ADDR = ADDR_W'(NUM_SRC);
   localparam ctrl_t READ_MASK = ~(CTRL_W'(1) << BIT_FORCE);

   if (NUM_SRC < 2) begin : g_bad_count
      $error("vec_irq_ctrl: NUM_SRC must be at least 2");
   end
   if ((2 ** ADDR_W) <= NUM_SRC) begin : g_bad_addr
      $error("vec_irq_ctrl: ADDR_W too narrow for source slots plus auxiliary slot");
   end

   ctrl_t              ctrl [NUM_SRC];
   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] grant;
   logic [IDX_W-1:0]   cur_idx;
   logic               any_pend;
   ctrl_t              aux_word;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
      vic_src_slot #(
         .IDX    (i),
         .ADDR_W (ADDR_W)
      ) u_slot (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .req_i     (req_i[i]),
         .wr_i      (bus_wr_i),
         .addr_i    (bus_addr_i),
         .wdata_i   (bus_wdata_i),
         .ack_hit_i (ack_i && grant[i]),
         .ctrl_o    (ctrl[i]),
         .pend_o    (pend[i])
      );
   end

   vic_prio_enc #(
      .NUM (NUM_SRC)
   ) u_prio (
      .pend_i  (pend),
      .grant_o (grant),
      .idx_o   (cur_idx),
      .any_o   (any_pend)
   );

   vic_aux_regs #(
      .ADDR_W (ADDR_W),
      .SLOT   (NUM_SRC)
   ) u_aux (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (bus_wr_i),
      .addr_i  (bus_addr_i),
      .wdata_i (bus_wdata_i),
      .word_o  (aux_word)
   );

   assign irq_o    = any_pend;
   assign vector_o = any_pend ? ctrl[cur_idx][VEC_W-1:0] : '0;

   always_comb begin
      bus_rdata_o = '0;
      if (bus_addr_i < AUX_ADDR) begin
         bus_rdata_o = ctrl[bus_addr_i] & READ_MASK;
      end else if (bus_addr_i == AUX_ADDR) begin
         bus_rdata_o = aux_word;
      end
   end

   AST_IRQ_FOLLOWS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!bus_wr_i && !ack_i && irq_o && (pend[cur_idx] && ctrl[cur_idx][BIT_EDGE])) |=> irq_o); // R8
   AST_READ_HIDES_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_addr_i < AUX_ADDR) |-> !bus_rdata_o[BIT_FORCE]); // R2
endmodule

// File: tb/tb_vec_irq_ctrl.sv
`timescale 1ns/1ps
module tb_vec_irq_ctrl;
   localparam int N  = 19;
   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  req = '0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [15:0]   bus_wdata = '0;
   logic [15:0]   bus_rdata;
   logic          ack = 1'b0;
   logic          irq;
   logic [7:0]    vector;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int          kq[$];
   logic [15:0] eq[$];
   string       tq[$];

   always #2 clk = ~clk;

   vec_irq_ctrl #(.NUM_SRC(N), .ADDR_W(AW)) dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .req_i       (req),
      .bus_wr_i    (bus_wr),
      .bus_addr_i  (bus_addr),
      .bus_wdata_i (bus_wdata),
      .bus_rdata_o (bus_rdata),
      .ack_i       (ack),
      .irq_o       (irq),
      .vector_o    (vector)
   );

   // monitor: pops expected items and compares them away from the clock edge
   always @(negedge clk) begin
      while (kq.size() != 0) begin
         int          k;
         logic [15:0] e, act;
         string       t;
         k = kq.pop_front();
         e = eq.pop_front();
         t = tq.pop_front();
         case (k)
            0:       act = bus_rdata;
            1:       act = {15'd0, irq};
            default: act = {8'd0, vector};
         endcase
         checks++;
         if (act !== e) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", t, act, e);
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic settle();
      wait (kq.size() == 0);
      #1;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      tick();
      bus_wr = 1'b0;
   endtask

   task automatic pulse_ack();
      ack = 1'b1;
      tick();
      ack = 1'b0;
   endtask

   task automatic chk_rd(input logic [AW-1:0] a, input logic [15:0] e, input string t);
      bus_addr = a;
      kq.push_back(0); eq.push_back(e); tq.push_back(t);
      settle();
   endtask

   task automatic chk_irq(input logic e, input string t);
      kq.push_back(1); eq.push_back({15'd0, e}); tq.push_back(t);
      settle();
   endtask

   task automatic chk_vec(input logic [7:0] e, input string t);
      kq.push_back(2); eq.push_back({8'd0, e}); tq.push_back(t);
      settle();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R8 watchdog actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1 reset state
      chk_rd(5'd0, 16'h0000, "R1 slot0 after reset");
      chk_rd(5'd19, 16'h0000, "R1 aux after reset");
      chk_irq(1'b0, "R1 irq after reset");
      chk_vec(8'h00, "R1 vector after reset");

      // R2 plain store and readback mask
      wr(5'd3, 16'h80A5);
      chk_rd(5'd3, 16'h00A5, "R2 bit15 masked");
      wr(5'd5, 16'h605A);
      chk_rd(5'd5, 16'h605A, "R2 plain store");

      // R3 disabled source ignored
      wr(5'd2, 16'h0022);
      req[2] = 1'b1;
      tick(); tick();
      chk_rd(5'd2, 16'h0022, "R3 disabled not pending");
      chk_irq(1'b0, "R3 disabled no irq");
      req[2] = 1'b0;
      tick();

      // R4 level mode
      wr(5'd4, 16'h0244);
      req[4] = 1'b1;
      tick();
      chk_rd(5'd4, 16'h0344, "R4 level pends");
      chk_irq(1'b1, "R4 irq up");
      chk_vec(8'h44, "R4 vector");
      req[4] = 1'b0;
      tick();
      chk_rd(5'd4, 16'h0244, "R4 withdraw clears");
      chk_irq(1'b0, "R4 irq down");

      // R5 edge mode
      wr(5'd6, 16'h1466);
      req[6] = 1'b1;
      tick();
      chk_rd(5'd6, 16'h1566, "R5 edge pends");
      req[6] = 1'b0;
      tick(); tick();
      chk_rd(5'd6, 16'h1566, "R5 edge held");
      chk_vec(8'h66, "R5 vector");
      pulse_ack();
      chk_rd(5'd6, 16'h1466, "R5 ack clears edge");
      chk_irq(1'b0, "R5 irq down");

      // R6 negative polarity
      wr(5'd7, 16'h0A77);
      tick();
      chk_rd(5'd7, 16'h0B77, "R6 low input active");
      chk_vec(8'h77, "R6 vector");
      req[7] = 1'b1;
      tick();
      chk_rd(5'd7, 16'h0A77, "R6 high input withdraws");

      // R8 priority
      wr(5'd9, 16'h0299);
      wr(5'd12, 16'h02CC);
      req[12] = 1'b1;
      tick();
      chk_vec(8'hCC, "R8 single source");
      req[9] = 1'b1;
      tick();
      chk_vec(8'h99, "R8 lower index wins");
      chk_irq(1'b1, "R8 irq with two");
      req[9] = 1'b0;
      tick();
      chk_vec(8'hCC, "R8 falls back");
      req[12] = 1'b0;
      tick();
      chk_irq(1'b0, "R8 none pending");
      chk_vec(8'h00, "R8 vector idle");

      // R9 acknowledge order
      wr(5'd10, 16'h14AA);
      wr(5'd11, 16'h14BB);
      req[10] = 1'b1; req[11] = 1'b1;
      tick();
      req[10] = 1'b0; req[11] = 1'b0;
      chk_vec(8'hAA, "R9 first current");
      pulse_ack();
      chk_vec(8'hBB, "R9 next after ack");
      chk_rd(5'd10, 16'h14AA, "R9 acked cleared");
      pulse_ack();
      chk_irq(1'b0, "R9 all acked");

      // R11 ack and new request in one cycle
      wr(5'd13, 16'h14DD);
      wr(5'd1, 16'h1411);
      req[13] = 1'b1;
      tick();
      req[13] = 1'b0;
      chk_vec(8'hDD, "R11 before collision");
      ack = 1'b1; req[1] = 1'b1;
      tick();
      ack = 1'b0; req[1] = 1'b0;
      chk_vec(8'h11, "R11 new request taken");
      chk_rd(5'd13, 16'h14DD, "R11 ack taken");
      pulse_ack();
      chk_irq(1'b0, "R11 drained");

      // R11 write and event on the same slot
      wr(5'd14, 16'h02EE);
      bus_wr = 1'b1; bus_addr = 5'd14; bus_wdata = 16'h02E0; req[14] = 1'b1;
      tick();
      bus_wr = 1'b0;
      chk_rd(5'd14, 16'h02E0, "R11 write wins");
      tick();
      chk_rd(5'd14, 16'h03E0, "R11 request after write");
      chk_vec(8'hE0, "R11 vector after write");
      req[14] = 1'b0;
      tick();
      chk_irq(1'b0, "R11 withdrawn");

      // R7 forced interrupt
      wr(5'd15, 16'h11F0);
      chk_rd(5'd15, 16'h10F0, "R7 arm reads clean");
      chk_irq(1'b0, "R7 arm no irq");
      wr(5'd15, 16'h10F5);
      chk_rd(5'd15, 16'h11F5, "R7 second write raises");
      chk_irq(1'b1, "R7 irq raised");
      chk_vec(8'hF5, "R7 vector");
      pulse_ack();
      chk_irq(1'b0, "R7 acked");
      wr(5'd15, 16'h10F6);
      chk_rd(5'd15, 16'h10F6, "R7 plain write no raise");
      chk_irq(1'b0, "R7 plain write irq low");
      wr(5'd16, 16'h0100);
      chk_rd(5'd16, 16'h0000, "R7 arm disabled slot");
      wr(5'd16, 16'h0016);
      chk_rd(5'd16, 16'h0016, "R7 disabled force dropped");
      chk_irq(1'b0, "R7 disabled force no irq");

      // R10 auxiliary storage
      wr(5'd19, 16'hC35A);
      chk_rd(5'd19, 16'hC35A, "R10 aux store");
      wr(5'd18, 16'h1234);
      chk_rd(5'd18, 16'h1234, "R10 neighbour slot");
      chk_rd(5'd19, 16'hC35A, "R10 aux unchanged");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule